// File: doc/BRIEF.md
# Multiplexed Address/Data Burst Bus Master

This block turns single requests from an internal port into accesses on an external 32-bit bus whose lines carry the address first and the data afterwards. Each accepted request produces one address clock and then one data beat, or four beats for a burst. During the address clock the shared lines carry a 3-bit size code and the 26-bit address. A separate non-multiplexed address bus repeats that address for the whole access. A programmable count of software wait clocks comes before the first beat. A device can stretch any beat by holding its wait input high. Reads always get one extra clock after the address clock, so the device has time to turn the bus around.

The internal side gives the address, size, direction, write data for up to four beats and a valid strobe. The block returns the read words and a one-clock done pulse. A request is taken only while the block is idle. The wait count is sampled when the request is accepted.

Top module: `mpx_burst_master`

## Requirements
- R1: The address clock is the first clock of the access and lasts exactly one clock. In it, bus_d_oe is 1, bus_bs_n is 0, bus_d_out[25:0] holds the request address and bus_d_out[28:26] is 000.
- R2: In the address clock, bus_d_out[31:29] carries the size code for req_size. req_size 0 (byte) gives 000, 1 (halfword) gives 001, 2 (longword) gives 010 and 3 (four-longword burst) gives 100.
- R3: bus_addr equals the request address in every clock in which bus_cs_n is low.
- R4: A read inserts exactly one clock between the address clock and the software waits. A write inserts none.
- R5: The sw_wait value sampled at acceptance adds that many clocks before the first beat only. The total number of clocks with bus_cs_n low is 1 + (read ? 1 : 0) + sw_wait + beats + the wait clocks.
- R6: A beat lasts one clock plus one clock for every clock in which bus_wait is high. The beat ends in the first of its clocks where bus_wait is low.
- R7: bus_bs_n is low for one clock in the address clock and in the first clock of each beat. A burst has four beats and every other size has one.
- R8: bus_cs_n and bus_frame_n are low from the address clock through the last beat, and high otherwise, including after reset.
- R9: On writes, bus_d_oe is 1 in every clock of the access, and bus_d_out carries word k of req_wdata (bits 32k+31..32k) during beat k. On reads, bus_d_oe is 0 in every clock of the access after the address clock.
- R10: On reads, bus_d_in is captured into word k of rsp_rdata in the clock where beat k ends. rsp_rdata is cleared to zero when a request is accepted.
- R11: rsp_done is high for exactly one clock, the clock right after the last beat, and bus_cs_n is high in that clock.
- R12: req_valid has no effect while an access is in progress. No second access starts and bus_addr keeps the accepted address.
- R13: bus_rd_wr is 0 during a write access and 1 during a read access and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wait | input | 4 | Software wait clock count, sampled at acceptance |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_addr | input | 26 | Access address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 longword, 3 four-longword burst |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 128 | Write words, word k used in beat k |
| rsp_rdata | output | 128 | Read words, word k from beat k |
| rsp_done | output | 1 | One-clock completion pulse |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_bs_n | output | 1 | Bus-start strobe, active low |
| bus_frame_n | output | 1 | Frame, active low |
| bus_rd_wr | output | 1 | 1 read, 0 write |
| bus_addr | output | 26 | Non-multiplexed address |
| bus_d_out | output | 32 | Shared lines, driven value |
| bus_d_in | input | 32 | Shared lines, sampled value |
| bus_d_oe | output | 1 | Drive enable for the shared lines |
| bus_wait | input | 1 | Device wait, high stretches the current beat |

## Verification
The stimulus varies the direction, all four sizes, software wait counts from zero to fifteen, and separate device-wait lengths for the first beat and for later beats. Comparing the count of selected clocks for a read and a write with zero waits isolates the fixed read gap. A nonzero software wait on a burst shows that the wait is applied only once. Giving different device-wait lengths to the first beat and the later beats shows that each beat is stretched on its own. Distinct data per beat shows the ordering of the write words and the captured read words. Directed cases cover the reset state, a request pulsed in the middle of a burst, and read data cleared by a following write.

// File: rtl/mpx_pkg.sv
package mpx_pkg;

  localparam int BUS_W    = 32;
  localparam int AFIELD_W = 26;
  localparam int CODE_W   = 3;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_BURST = 2'd3
  } size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RDGAP,
    ST_SWAIT,
    ST_BEAT,
    ST_DONE
  } state_e;

  function automatic logic [CODE_W-1:0] size_code(size_e s);
    case (s)
      SZ_BYTE:  return 3'b000;
      SZ_HALF:  return 3'b001;
      SZ_WORD:  return 3'b010;
      default:  return 3'b100;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] addr_word(logic [CODE_W-1:0] code,
                                                  logic [AFIELD_W-1:0] a);
    return {code, {(BUS_W-CODE_W-AFIELD_W){1'b0}}, a};
  endfunction

  function automatic bit is_last_swait(int unsigned cnt, int unsigned limit);
    return (cnt + 1) == limit;
  endfunction

endpackage

// File: rtl/mpx_wait_timer.sv
module mpx_wait_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         last
);
  import mpx_pkg::*;

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (step)   cnt <= cnt + 1'b1;
  end

  assign last = is_last_swait(int'(cnt), int'(limit));
endmodule

// File: rtl/mpx_beat_ctr.sv
module mpx_beat_ctr #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  input  logic [IDX_W-1:0] last_idx,
  output logic [IDX_W-1:0] idx,
  output logic             is_last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= '0;
    else if (clear) idx <= '0;
    else if (adv)   idx <= idx + 1'b1;
  end

  assign is_last = (idx == last_idx);
endmodule

// File: rtl/mpx_seq.sv
module mpx_seq
  import mpx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   is_write,
  input  logic   sw_zero,
  input  logic   sw_last,
  input  logic   bus_wait,
  input  logic   beat_last,
  output logic   accept,
  output logic   ev_addr,
  output logic   in_beat,
  output logic   beat_new,
  output logic   active,
  output logic   done,
  output logic   timer_clear,
  output logic   timer_step,
  output logic   beat_clear,
  output logic   beat_adv
);
  state_e state, nxt;
  logic   beat_new_q;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (req_valid) nxt = ST_ADDR;
      ST_ADDR:  nxt = !is_write ? ST_RDGAP : (sw_zero ? ST_BEAT : ST_SWAIT);
      ST_RDGAP: nxt = sw_zero ? ST_BEAT : ST_SWAIT;
      ST_SWAIT: if (sw_last) nxt = ST_BEAT;
      ST_BEAT:  if (!bus_wait && beat_last) nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      beat_new_q <= 1'b0;
    end else begin
      state      <= nxt;
      beat_new_q <= (nxt == ST_BEAT) && ((state != ST_BEAT) || !bus_wait);
    end
  end

  assign accept      = (state == ST_IDLE) && req_valid;
  assign ev_addr     = (state == ST_ADDR);
  assign in_beat     = (state == ST_BEAT);
  assign beat_new    = in_beat && beat_new_q;
  assign active      = (state == ST_ADDR) || (state == ST_RDGAP) ||
                       (state == ST_SWAIT) || (state == ST_BEAT);
  assign done        = (state == ST_DONE);
  assign timer_clear = (state != ST_SWAIT);
  assign timer_step  = (state == ST_SWAIT);
  assign beat_clear  = (state == ST_ADDR);
  assign beat_adv    = in_beat && !bus_wait && !beat_last;
endmodule

// File: rtl/mpx_burst_master.sv
module mpx_burst_master
  import mpx_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int WAIT_W    = 4,
  parameter int MAX_BEATS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WAIT_W-1:0]          sw_wait,
  input  logic                       req_valid,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [1:0]                 req_size,
  input  logic                       req_write,
  input  logic [MAX_BEATS*BUS_W-1:0] req_wdata,
  output logic [MAX_BEATS*BUS_W-1:0] rsp_rdata,
  output logic                       rsp_done,
  output logic                       bus_cs_n,
  output logic                       bus_bs_n,
  output logic                       bus_frame_n,
  output logic                       bus_rd_wr,
  output logic [ADDR_W-1:0]          bus_addr,
  output logic [BUS_W-1:0]           bus_d_out,
  input  logic [BUS_W-1:0]           bus_d_in,
  output logic                       bus_d_oe,
  input  logic                       bus_wait
);
  localparam int IDX_W = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;

  logic [ADDR_W-1:0] addr_q;
  size_e             size_q;
  logic              write_q;
  logic [WAIT_W-1:0] sw_q;
  logic [IDX_W-1:0]  last_idx_q;
  logic [BUS_W-1:0]  wr_words [MAX_BEATS];
  logic [BUS_W-1:0]  rd_words [MAX_BEATS];
  logic [MAX_BEATS*BUS_W-1:0] wdata_q;

  logic accept, ev_addr, in_beat, beat_new, active, done;
  logic timer_clear, timer_step, beat_clear, beat_adv;
  logic sw_last, beat_last;
  logic [IDX_W-1:0] beat_idx;
  logic ev_beat_end;

  mpx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .is_write(write_q),
    .sw_zero(sw_q == '0), .sw_last(sw_last), .bus_wait(bus_wait),
    .beat_last(beat_last), .accept(accept), .ev_addr(ev_addr),
    .in_beat(in_beat), .beat_new(beat_new), .active(active), .done(done),
    .timer_clear(timer_clear), .timer_step(timer_step),
    .beat_clear(beat_clear), .beat_adv(beat_adv)
  );

  mpx_wait_timer #(.W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(timer_clear), .step(timer_step),
    .limit(sw_q), .last(sw_last)
  );

  mpx_beat_ctr #(.IDX_W(IDX_W)) u_beats (
    .clk(clk), .rst_n(rst_n), .clear(beat_clear), .adv(beat_adv),
    .last_idx(last_idx_q), .idx(beat_idx), .is_last(beat_last)
  );

  assign ev_beat_end = in_beat && !bus_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      size_q     <= SZ_BYTE;
      write_q    <= 1'b0;
      sw_q       <= '0;
      last_idx_q <= '0;
      wdata_q    <= '0;
    end else if (accept) begin
      addr_q     <= req_addr;
      size_q     <= size_e'(req_size);
      write_q    <= req_write;
      sw_q       <= sw_wait;
      last_idx_q <= (size_e'(req_size) == SZ_BURST) ? IDX_W'(MAX_BEATS-1) : '0;
      wdata_q    <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_BEATS; i++) rd_words[i] <= '0;
    end else if (accept) begin
      for (int i = 0; i < MAX_BEATS; i++) rd_words[i] <= '0;
    end else if (ev_beat_end && !write_q) begin
      rd_words[beat_idx] <= bus_d_in;
    end
  end

  for (genvar g = 0; g < MAX_BEATS; g++) begin : g_words
    assign wr_words[g] = wdata_q[g*BUS_W +: BUS_W];
    assign rsp_rdata[g*BUS_W +: BUS_W] = rd_words[g];
  end

  always_comb begin
    if (ev_addr)
      bus_d_out = addr_word(size_code(size_q), AFIELD_W'(addr_q));
    else
      bus_d_out = wr_words[beat_idx];
  end

  assign bus_d_oe    = ev_addr || (active && write_q);
  assign bus_cs_n    = !active;
  assign bus_frame_n = !active;
  assign bus_bs_n    = !(ev_addr || beat_new);
  assign bus_rd_wr   = !(active && write_q);
  assign bus_addr    = addr_q;
  assign rsp_done    = done;
endmodule

// File: rtl/mpx_burst_master_chk.sv
module mpx_burst_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_addr,
  input logic        in_beat,
  input logic        bus_cs_n,
  input logic        bus_bs_n,
  input logic        bus_frame_n,
  input logic        bus_rd_wr,
  input logic [25:0] bus_addr,
  input logic [31:0] bus_d_out,
  input logic        bus_d_oe,
  input logic        bus_wait,
  input logic        rsp_done
);
  a_r1_addr_word: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr |-> (bus_d_oe && !bus_bs_n && bus_d_out[25:0] == bus_addr &&
                 bus_d_out[28:26] == 3'b000));

  a_r2_size_code: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr |-> ($countones(bus_d_out[31:29]) <= 1));

  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));

  a_r4_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_addr && bus_rd_wr) |=> (!bus_cs_n && bus_bs_n && !bus_d_oe));

  a_r6_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_beat && bus_wait) |=> (in_beat && bus_bs_n && !bus_cs_n));

  a_r8_frame_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs_n |-> !bus_frame_n);

  a_r9_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && bus_rd_wr && !ev_addr) |-> !bus_d_oe);

  a_r11_done_after: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (bus_cs_n && $past(!bus_cs_n)));
endmodule

bind mpx_burst_master mpx_burst_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_addr(ev_addr), .in_beat(in_beat),
  .bus_cs_n(bus_cs_n), .bus_bs_n(bus_bs_n), .bus_frame_n(bus_frame_n),
  .bus_rd_wr(bus_rd_wr), .bus_addr(bus_addr), .bus_d_out(bus_d_out),
  .bus_d_oe(bus_d_oe), .bus_wait(bus_wait), .rsp_done(rsp_done)
);

// File: tb/mpx_burst_master_test.sv
module mpx_burst_master_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   sw_wait = '0;
  logic         req_valid = 1'b0;
  logic [25:0]  req_addr = '0;
  logic [1:0]   req_size = '0;
  logic         req_write = 1'b0;
  logic [127:0] req_wdata = '0;
  logic [127:0] rsp_rdata;
  logic         rsp_done, bus_cs_n, bus_bs_n, bus_frame_n, bus_rd_wr, bus_d_oe;
  logic [25:0]  bus_addr;
  logic [31:0]  bus_d_out;
  logic [31:0]  bus_d_in = '0;
  logic         bus_wait = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 0;

  mpx_burst_master uut (
    .clk(clk), .rst_n(rst_n), .sw_wait(sw_wait), .req_valid(req_valid),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .bus_cs_n(bus_cs_n), .bus_bs_n(bus_bs_n), .bus_frame_n(bus_frame_n),
    .bus_rd_wr(bus_rd_wr), .bus_addr(bus_addr), .bus_d_out(bus_d_out),
    .bus_d_in(bus_d_in), .bus_d_oe(bus_d_oe), .bus_wait(bus_wait)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {write, size, sw_wait, first-beat waits, later-beat waits, address}
  localparam int NV = 8;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 2'd0, 4'd0,  4'd0, 4'd0, 26'h0000123},
    {1'b1, 2'd0, 4'd0,  4'd0, 4'd0, 26'h3FFFFFF},
    {1'b1, 2'd1, 4'd3,  4'd0, 4'd0, 26'h1555555},
    {1'b0, 2'd2, 4'd2,  4'd3, 4'd0, 26'h2AAAAAA},
    {1'b0, 2'd3, 4'd0,  4'd0, 4'd0, 26'h0000040},
    {1'b1, 2'd3, 4'd2,  4'd1, 4'd2, 26'h0123456},
    {1'b0, 2'd3, 4'd5,  4'd2, 4'd1, 26'h3000008},
    {1'b1, 2'd2, 4'd15, 4'd0, 4'd0, 26'h0ABCDEF}
  };

  function automatic logic [31:0] wr_word(logic [25:0] a, int k);
    return {a, 6'h15} + 32'(k) * 32'h1000_0001;
  endfunction

  function automatic logic [31:0] rd_word(logic [25:0] a, int k);
    return {6'h2A, a} ^ (32'h0101_0101 * 32'(k + 1));
  endfunction

  function automatic logic [2:0] exp_code(logic [1:0] s);
    case (s)
      2'd0: return 3'b000;
      2'd1: return 3'b001;
      2'd2: return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic run_access(input logic wr, input logic [1:0] sz, input logic [3:0] sw,
                            input logic [3:0] w1, input logic [3:0] wl,
                            input logic [25:0] a, input bit poke);
    int nb, ncs, nbs, beat, wcnt, bad_addr, bad_fr, bad_oe, bad_wd, exp_cs;
    logic [31:0] aw;
    logic aoe, abs, ard;
    bit got_done;
    logic [127:0] exp_rd;
    nb = (sz == 2'd3) ? 4 : 1;
    ncs = 0; nbs = 0; beat = -1; wcnt = 0;
    bad_addr = 0; bad_fr = 0; bad_oe = 0; bad_wd = 0; got_done = 0;
    aw = '0; aoe = 0; abs = 1; ard = 0;
    @(negedge clk);
    for (int k = 0; k < 4; k++) req_wdata[k*32 +: 32] = wr_word(a, k);
    req_write = wr; req_size = sz; sw_wait = sw; req_addr = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    sw_wait = 4'd0;
    for (int g = 0; g < 400; g++) begin
      if (!bus_cs_n) begin
        if (ncs == 0) begin
          aw = bus_d_out; aoe = bus_d_oe; abs = bus_bs_n; ard = bus_rd_wr;
        end else begin
          if (!bus_bs_n) begin
            beat++;
            wcnt = (beat == 0) ? int'(w1) : int'(wl);
            bus_wait = (wcnt != 0);
            bus_d_in = rd_word(a, beat);
            if (wr && !(bus_d_oe && bus_d_out == wr_word(a, beat))) bad_wd++;
          end else if (bus_wait) begin
            wcnt--;
            bus_wait = (wcnt != 0);
          end
          if (!wr && bus_d_oe) bad_oe++;
        end
        if (wr && !bus_d_oe) bad_oe++;
        if (bus_addr != a) bad_addr++;
        if (bus_frame_n) bad_fr++;
        if (!bus_bs_n) nbs++;
        ncs++;
        if (poke && ncs == 3) begin
          req_valid = 1'b1; req_addr = ~a;
        end else begin
          req_valid = 1'b0;
        end
      end else begin
        got_done = rsp_done;
        break;
      end
      @(negedge clk);
    end
    bus_wait = 1'b0;
    req_valid = 1'b0;
    exp_cs = 1 + (wr ? 0 : 1) + int'(sw) + nb + int'(w1) + (nb - 1) * int'(wl);
    chk(ncs == exp_cs, "R4 R5 R6 selected clocks", ncs, exp_cs);
    chk(nbs == 1 + nb, "R7 strobe count", nbs, 1 + nb);
    chk(aw[25:0] == a && aw[28:26] == 3'b000 && aoe && !abs, "R1 address clock",
        {aoe, abs, aw}, {1'b1, 1'b0, exp_code(sz), 3'b000, a});
    chk(aw[31:29] == exp_code(sz), "R2 size code", aw[31:29], exp_code(sz));
    chk(ard == !wr, "R13 direction", ard, !wr);
    chk(bad_addr == 0, "R3 address pins", bad_addr, 0);
    chk(bad_fr == 0, "R8 frame", bad_fr, 0);
    chk(bad_oe == 0, "R9 drive enable", bad_oe, 0);
    if (wr) chk(bad_wd == 0, "R9 write words", bad_wd, 0);
    chk(got_done, "R11 done after last beat", got_done, 1);
    exp_rd = '0;
    if (!wr) for (int k = 0; k < nb; k++) exp_rd[k*32 +: 32] = rd_word(a, k);
    chk(rsp_rdata == exp_rd, "R10 read words", rsp_rdata, exp_rd);
    @(negedge clk);
    chk(!rsp_done && bus_cs_n && bus_rd_wr, "R11 done single clock",
        {rsp_done, bus_cs_n, bus_rd_wr}, 3'b011);
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(bus_cs_n && bus_addr == a, "R12 request ignored while busy",
            {bus_cs_n, bus_addr}, {1'b1, a});
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_cs_n && bus_frame_n && bus_bs_n && !bus_d_oe && !rsp_done && bus_rd_wr,
        "R8 reset state", {bus_cs_n, bus_frame_n, bus_bs_n, bus_d_oe, rsp_done, bus_rd_wr},
        6'b111001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_cs_n && rsp_rdata == '0, "R10 idle after reset", {bus_cs_n, rsp_rdata},
        {1'b1, 128'h0});
    for (int v = 0; v < NV; v++) begin
      run_access(VEC[v][40], VEC[v][39:38], VEC[v][37:34], VEC[v][33:30],
                 VEC[v][29:26], VEC[v][25:0], 1'b0);
    end
    // R12: a strobe in the middle of a write burst starts nothing
    run_access(1'b1, 2'd3, 4'd1, 4'd0, 4'd1, 26'h1234567, 1'b1);
    // R10: read burst then write clears captured words
    run_access(1'b0, 2'd3, 4'd0, 4'd1, 4'd0, 26'h0F0F0F0, 1'b0);
    run_access(1'b1, 2'd0, 4'd0, 4'd0, 4'd0, 26'h0000001, 1'b0);
    // R4: read with zero waits and max software wait on a burst
    run_access(1'b0, 2'd3, 4'd15, 4'd0, 4'd3, 26'h2222222, 1'b0);
    summary();
  end
endmodule